// File: doc/BRIEF.md
# Dual-Mode Interval and Seconds Timer

This peripheral sits on a simple register bus: address, write strobe, write data, and read data that is combinational from the address. Software picks one of two counting modes through the configuration register and starts or stops the chosen engine with a single enable bit in the control register.

In countdown mode a 32-bit counter loads from the load register when the enable bit goes from 0 to 1. When it has counted down through zero, it signals expiry. The counter then either reloads and runs again (periodic) or clears the enable bit (one-shot). An expiry can also produce a one-cycle trigger pulse for a neighbouring block. In seconds mode an internal prescaler divides the input clock down to a 1 Hz tick. A seconds counter advances on each tick and returns to zero when it would pass a programmable match value.

Events are latched in a raw status register and cleared by writing ones. A mask register gates the status onto one level interrupt line.

Top module: `tmr_periph`

## Requirements
- R1: After reset every register reads 0, the seconds count is 0, and irq_o and trig_o are low.
- R2: The configuration (0x00), mode (0x04), control (0x0C), load (0x28) and match (0x30) registers read back the full 32-bit value written. Any offset outside the register map reads 0, and a write to it changes no register. The registers at 0x1C, 0x20 and 0x48 are read-only.
- R3: With configuration 0, a write that changes control bit 0 from 0 to 1 loads the counter from the load register. The first expiry occurs on the (load+1)-th rising clock edge after that write's edge. Writing control with bit 0 still 1 does not restart the count.
- R4: Each expiry sets raw status (0x1C) bit 0. If control bit 5 is 1, trig_o is high for exactly the one cycle that follows the expiry edge. If control bit 5 is 0, trig_o stays low.
- R5: If mode bit 0 is 1, the expiry edge clears control bit 0 and no further expiry follows. If mode bit 0 is 0, expiries repeat every load+1 cycles.
- R6: A write that clears control bit 0 halts whichever engine is running. No further expiry occurs and the seconds count holds its value.
- R7: With configuration 1 and control bit 0 set, a tick occurs every TICK_DIV cycles, counted from the enabling write's edge. On each tick the seconds count (0x48) becomes count+1, or 0 if count+1 exceeds the match value. Reaching 0 sets raw status bit 3.
- R8: A write to the mask register (0x18) keeps only the bits in 0x77. Masked status (0x20) equals raw status AND mask. irq_o is high exactly when masked status is nonzero, so raw bit 3 never reaches the interrupt.
- R9: Writing the clear register (0x24) clears each raw status bit written as 1. The clear register reads 0.
- R10: Offset 0x48 returns the seconds count when the configuration is 1 and returns 0 for any other configuration value.
- R11: A load value of 0 in periodic countdown mode expires on every clock edge while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt, masked status nonzero |
| trig_o | output | 1 | One-cycle pulse on countdown expiry when enabled |

## Verification
The bench builds the block with TICK_DIV set to 10 and ADDR_W at its default of 12. With a divider that short, seconds ticks, the wrap at a small match value and the raw bit 3 event all occur within a few dozen cycles instead of a second of clock. The 12-bit address lets random bus traffic land on unmapped offsets next to the mapped ones. Countdown timing is measured cycle by cycle at load values 0, 2, 3 and 4, which covers back-to-back expiries, one-shot termination and a redundant enable write in the middle of a period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned REG_W = 32;

   localparam int unsigned OFS_CFG    = 'h00;
   localparam int unsigned OFS_MODE   = 'h04;
   localparam int unsigned OFS_CTRL   = 'h0C;
   localparam int unsigned OFS_MASK   = 'h18;
   localparam int unsigned OFS_RAW    = 'h1C;
   localparam int unsigned OFS_MSK_ST = 'h20;
   localparam int unsigned OFS_CLR    = 'h24;
   localparam int unsigned OFS_LOAD   = 'h28;
   localparam int unsigned OFS_MATCH  = 'h30;
   localparam int unsigned OFS_VALUE  = 'h48;
   localparam int unsigned OFS_TOP    = OFS_VALUE;

   localparam logic [REG_W-1:0] CFG_DOWN = 32'd0;
   localparam logic [REG_W-1:0] CFG_SECS = 32'd1;

   localparam int unsigned CTRL_EN_BIT      = 0;
   localparam int unsigned CTRL_TRIG_BIT    = 5;
   localparam int unsigned MODE_ONESHOT_BIT = 0;
   localparam int unsigned STAT_DOWN_BIT    = 0;
   localparam int unsigned STAT_SECS_BIT    = 3;

   localparam logic [REG_W-1:0] MASK_KEEP = 32'h0000_0077;

   typedef enum logic [3:0] {
      SEL_CFG, SEL_MODE, SEL_CTRL, SEL_MASK, SEL_RAW, SEL_MSK_ST,
      SEL_CLR, SEL_LOAD, SEL_MATCH, SEL_VALUE, SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int unsigned TICK_DIV = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   output logic tick_o
);
   localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (TICK_DIV < 1) begin : g_bad_div
      $error("tmr_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_direct
      assign tick_o = run_i && !restart_i;
   end else begin : g_divide
      localparam logic [CW-1:0] TERM = CW'(TICK_DIV - 1);
      logic [CW-1:0] pre_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pre_q <= '0;
         end else if (restart_i) begin
            pre_q <= '0;
         end else if (run_i) begin
            if (pre_q == TERM) pre_q <= '0;
            else               pre_q <= pre_q + 1'b1;
         end
      end

      assign tick_o = run_i && !restart_i && (pre_q == TERM);

      AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pre_q <= TERM); // R7
   end
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             expire_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("tmr_down: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= load_i;
      end else if (run_i) begin
         if (cnt_q == '0) cnt_q <= load_i;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = run_i && !start_i && (cnt_q == '0);

   AST_NO_EARLY_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && !start_i && (cnt_q > CNT_W'(1)) |=> !expire_o); // R3
endmodule

// File: rtl/tmr_secs.sv
module tmr_secs #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] match_i,
   output logic [CNT_W-1:0] count_o,
   output logic             zero_hit_o
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] inc;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      inc = count_q + 1'b1;
      nxt = (inc > match_i) ? '0 : inc;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     count_q <= '0;
      else if (tick_i) count_q <= nxt;
   end

   assign count_o    = count_q;
   assign zero_hit_o = tick_i && (nxt == '0);

   AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && (count_q >= match_i) |=> count_q == '0); // R7
   AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(count_q)); // R6
endmodule

// File: rtl/tmr_periph.sv
module tmr_periph
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned TICK_DIV = 50_000_000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [REG_W-1:0]  bus_wdata_i,
   output logic [REG_W-1:0]  bus_rdata_o,
   output logic              irq_o,
   output logic              trig_o
);
   if (ADDR_W < $clog2(OFS_TOP + 1)) begin : g_bad_addr
      $error("tmr_periph: ADDR_W too narrow for the register map");
   end

   reg_sel_e sel;
   logic [REG_W-1:0] cfg_q, mode_q, ctrl_q, mask_q, raw_q, load_q, match_q;
   logic [REG_W-1:0] sec_count, masked;
   logic wr_cfg, wr_mode, wr_ctrl, wr_mask, wr_clr, wr_load, wr_match;
   logic en_rise, dn_run, dn_expire, sec_run, sec_tick, sec_zero;
   logic trig_q;

   // address decode
   always_comb begin
      case (bus_addr_i)
         ADDR_W'(OFS_CFG):    sel = SEL_CFG;
         ADDR_W'(OFS_MODE):   sel = SEL_MODE;
         ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
         ADDR_W'(OFS_MASK):   sel = SEL_MASK;
         ADDR_W'(OFS_RAW):    sel = SEL_RAW;
         ADDR_W'(OFS_MSK_ST): sel = SEL_MSK_ST;
         ADDR_W'(OFS_CLR):    sel = SEL_CLR;
         ADDR_W'(OFS_LOAD):   sel = SEL_LOAD;
         ADDR_W'(OFS_MATCH):  sel = SEL_MATCH;
         ADDR_W'(OFS_VALUE):  sel = SEL_VALUE;
         default:             sel = SEL_NONE;
      endcase
   end

   assign wr_cfg   = bus_we_i && (sel == SEL_CFG);
   assign wr_mode  = bus_we_i && (sel == SEL_MODE);
   assign wr_ctrl  = bus_we_i && (sel == SEL_CTRL);
   assign wr_mask  = bus_we_i && (sel == SEL_MASK);
   assign wr_clr   = bus_we_i && (sel == SEL_CLR);
   assign wr_load  = bus_we_i && (sel == SEL_LOAD);
   assign wr_match = bus_we_i && (sel == SEL_MATCH);

   assign en_rise = wr_ctrl && bus_wdata_i[CTRL_EN_BIT] && !ctrl_q[CTRL_EN_BIT];
   assign dn_run  = ctrl_q[CTRL_EN_BIT] && (cfg_q == CFG_DOWN);
   assign sec_run = ctrl_q[CTRL_EN_BIT] && (cfg_q == CFG_SECS);

   // plain configuration registers
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q   <= '0;
         mode_q  <= '0;
         mask_q  <= '0;
         load_q  <= '0;
         match_q <= '0;
      end else begin
         if (wr_cfg)   cfg_q   <= bus_wdata_i;
         if (wr_mode)  mode_q  <= bus_wdata_i;
         if (wr_mask)  mask_q  <= bus_wdata_i & MASK_KEEP;
         if (wr_load)  load_q  <= bus_wdata_i;
         if (wr_match) match_q <= bus_wdata_i;
      end
   end

   // control: a bus write wins over the one-shot self-clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= bus_wdata_i;
      end else if (dn_expire && mode_q[MODE_ONESHOT_BIT]) begin
         ctrl_q[CTRL_EN_BIT] <= 1'b0;
      end
   end

   // raw status: events set, write-one clears, set wins on collision
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~(wr_clr ? bus_wdata_i : '0))
                | (REG_W'(dn_expire) << STAT_DOWN_BIT)
                | (REG_W'(sec_zero)  << STAT_SECS_BIT);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) trig_q <= 1'b0;
      else         trig_q <= dn_expire && ctrl_q[CTRL_TRIG_BIT];
   end

   tmr_down #(.CNT_W(REG_W)) u_down (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (en_rise),
      .run_i    (dn_run),
      .load_i   (load_q),
      .expire_o (dn_expire)
   );

   tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (sec_run),
      .restart_i (en_rise),
      .tick_o    (sec_tick)
   );

   tmr_secs #(.CNT_W(REG_W)) u_secs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (sec_tick),
      .match_i    (match_q),
      .count_o    (sec_count),
      .zero_hit_o (sec_zero)
   );

   assign masked = raw_q & mask_q;

   always_comb begin
      case (sel)
         SEL_CFG:    bus_rdata_o = cfg_q;
         SEL_MODE:   bus_rdata_o = mode_q;
         SEL_CTRL:   bus_rdata_o = ctrl_q;
         SEL_MASK:   bus_rdata_o = mask_q;
         SEL_RAW:    bus_rdata_o = raw_q;
         SEL_MSK_ST: bus_rdata_o = masked;
         SEL_LOAD:   bus_rdata_o = load_q;
         SEL_MATCH:  bus_rdata_o = match_q;
         SEL_VALUE:  bus_rdata_o = (cfg_q == CFG_SECS) ? sec_count : '0;
         default:    bus_rdata_o = '0;
      endcase
   end

   assign irq_o  = |masked;
   assign trig_o = trig_q;

   AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dn_expire && mode_q[MODE_ONESHOT_BIT] && !wr_ctrl |=> !ctrl_q[CTRL_EN_BIT]); // R5
   AST_TRIG_WITH_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> raw_q[STAT_DOWN_BIT]); // R4
   AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_q == '0) |-> !irq_o); // R8
   AST_SECS_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(raw_q[STAT_SECS_BIT]) && !raw_q[STAT_DOWN_BIT] |-> !irq_o); // R8
   AST_CLR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel == SEL_CLR) |-> bus_rdata_o == '0); // R9
   AST_STOPPED_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_ctrl && !bus_wdata_i[CTRL_EN_BIT] |=> !dn_expire); // R6
endmodule

// File: tb/tmr_periph_tb.sv
module tmr_periph_tb_top;
   localparam int unsigned TB_DIV = 10;
   localparam time CLK_P = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, trig;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_cfg, m_mode, m_ctrl, m_mask, m_load, m_match;

   tmr_periph #(.ADDR_W(12), .TICK_DIV(TB_DIV)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq), .trig_o(trig)
   );

   always #(CLK_P/2) clk = ~clk;

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000: return m_cfg;
         12'h004: return m_mode;
         12'h00C: return m_ctrl;
         12'h018: return m_mask;
         12'h028: return m_load;
         12'h030: return m_match;
         default: return 32'h0;
      endcase
   endfunction

   function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
      case (a)
         12'h000: m_cfg   = d;
         12'h004: m_mode  = d;
         12'h00C: m_ctrl  = d;
         12'h018: m_mask  = d & 32'h77;
         12'h028: m_load  = d;
         12'h030: m_match = d;
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] next_sec(input logic [31:0] c, input logic [31:0] m);
      return (c + 32'd1 > m) ? 32'd0 : c + 32'd1;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      bus_addr = a; bus_we = 1'b0;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic count_trig(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (trig) c++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [11:0] ofs_list [13];
      int c;
      logic [31:0] sc;
      void'($urandom(32'h5EED_0042));
      ofs_list = '{12'h000, 12'h004, 12'h00C, 12'h018, 12'h01C, 12'h020, 12'h024,
                   12'h028, 12'h030, 12'h048, 12'h010, 12'h014, 12'h040};
      m_cfg = 0; m_mode = 0; m_ctrl = 0; m_mask = 0; m_load = 0; m_match = 0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      foreach (ofs_list[i]) rd_chk(ofs_list[i], 32'h0, "R1 reset read");
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 trig", {31'h0, trig}, 32'h0);

      // R2: random register traffic, enable bit held low
      for (int it = 0; it < 150; it++) begin
         logic [11:0] a;
         logic [31:0] d;
         a = ofs_list[$urandom % 13];
         d = $urandom;
         if (a == 12'h00C) d[0] = 1'b0;
         wr(a, d);
         model_write(a, d);
         a = ofs_list[$urandom % 13];
         rd_chk(a, exp_read(a), "R2 random readback");
      end
      wr(12'h014, 32'hFFFF_FFFF);
      rd_chk(12'h014, 32'h0, "R2 unknown offset");
      rd_chk(12'h028, m_load, "R2 load after unknown write");
      rd_chk(12'h030, m_match, "R2 match after unknown write");

      wr(12'h00C, 0); wr(12'h000, 0); wr(12'h004, 0); wr(12'h018, 0);
      wr(12'h024, 32'hFFFF_FFFF);

      // R3/R4/R5: periodic countdown, load 4
      wr(12'h028, 4);
      wr(12'h00C, 32'h21);
      repeat (4) @(negedge clk);
      check("R3 no early expiry", {31'h0, trig}, 32'h0);
      @(negedge clk);
      check("R4 trig at load+1", {31'h0, trig}, 32'h1);
      rd_chk(12'h01C, 32'h1, "R4 raw bit0");
      @(negedge clk);
      check("R4 trig single cycle", {31'h0, trig}, 32'h0);
      repeat (3) @(negedge clk);
      check("R5 periodic quiet", {31'h0, trig}, 32'h0);
      @(negedge clk);
      check("R5 periodic second expiry", {31'h0, trig}, 32'h1);
      // R3: redundant enable write does not restart
      wr(12'h00C, 32'h21);
      repeat (3) @(negedge clk);
      check("R3 rewrite quiet", {31'h0, trig}, 32'h0);
      @(negedge clk);
      check("R3 rewrite keeps period", {31'h0, trig}, 32'h1);
      // R6: stop
      wr(12'h00C, 0);
      count_trig(30, c);
      check("R6 stopped countdown", c, 0);

      // R8: mask and interrupt
      check("R8 irq masked off", {31'h0, irq}, 32'h0);
      wr(12'h018, 32'hFFFF_FFFF);
      rd_chk(12'h018, 32'h77, "R8 mask keeps 0x77");
      check("R8 irq raised", {31'h0, irq}, 32'h1);
      rd_chk(12'h020, 32'h1, "R8 masked status");
      // R9: clear
      wr(12'h024, 32'h1);
      rd_chk(12'h01C, 32'h0, "R9 raw cleared");
      check("R9 irq after clear", {31'h0, irq}, 32'h0);
      rd_chk(12'h024, 32'h0, "R9 clear reads zero");

      // R5: one-shot, load 3
      wr(12'h004, 1); wr(12'h028, 3);
      wr(12'h00C, 32'h21);
      repeat (3) @(negedge clk);
      check("R5 one-shot quiet", {31'h0, trig}, 32'h0);
      @(negedge clk);
      check("R5 one-shot expiry", {31'h0, trig}, 32'h1);
      rd_chk(12'h00C, 32'h20, "R5 enable self-cleared");
      count_trig(20, c);
      check("R5 one-shot no repeat", c, 0);

      // R4: expiry without trigger enable
      wr(12'h004, 0); wr(12'h028, 2); wr(12'h024, 32'hFF);
      wr(12'h00C, 32'h01);
      count_trig(12, c);
      check("R4 no trig when bit5 low", c, 0);
      rd_chk(12'h01C, 32'h1, "R4 raw set without trig");
      wr(12'h00C, 0);

      // R11: load 0 expires every cycle
      wr(12'h028, 0);
      wr(12'h00C, 32'h21);
      count_trig(10, c);
      check("R11 load zero every cycle", c, 10);
      wr(12'h00C, 0);
      repeat (2) @(negedge clk);

      // R7: seconds counter, match 2
      wr(12'h024, 32'hFF);
      wr(12'h000, 1); wr(12'h030, 2);
      sc = 0;
      wr(12'h00C, 32'h01);
      repeat (TB_DIV - 1) @(negedge clk);
      rd_chk(12'h048, sc, "R7 before first tick");
      @(negedge clk);
      sc = next_sec(sc, 2);
      rd_chk(12'h048, sc, "R7 first tick");
      repeat (TB_DIV) @(negedge clk);
      sc = next_sec(sc, 2);
      rd_chk(12'h048, sc, "R7 second tick");
      rd_chk(12'h01C, 32'h0, "R7 no zero event yet");
      repeat (TB_DIV) @(negedge clk);
      sc = next_sec(sc, 2);
      rd_chk(12'h048, sc, "R7 wrap past match");
      rd_chk(12'h01C, 32'h8, "R7 raw bit3 on zero");
      rd_chk(12'h020, 32'h0, "R8 bit3 outside mask");
      check("R8 irq stays low", {31'h0, irq}, 32'h0);
      repeat (TB_DIV) @(negedge clk);
      sc = next_sec(sc, 2);
      rd_chk(12'h048, sc, "R7 count after wrap");
      // R6: stop holds the count
      wr(12'h00C, 0);
      repeat (30) @(negedge clk);
      rd_chk(12'h048, sc, "R6 seconds held");
      // R10: value register depends on configuration
      wr(12'h000, 0);
      rd_chk(12'h048, 32'h0, "R10 value in countdown config");
      wr(12'h000, 1);
      rd_chk(12'h048, sc, "R10 value in seconds config");

      finish_run();
   end
endmodule